// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges the reset requests of a small microcontroller into a single system reset and keeps a record of what caused the latest one. Six request lines enter it: power-on, external pin, low-voltage, watchdog timeout, illegal opcode and debugger-forced. A seventh cause, the illegal-address reset, is generated inside the block. It compares each valid bus address against a parameter table of unimplemented ranges.

Any active request asserts `sys_rst` at once, without waiting for a clock edge. Release goes through a two-flop synchroniser. A stretch counter then keeps `sys_rst` high for a minimum hold time after the last request drops. While reset is active, the block presents the start-up CPU state: a stack pointer of 0x00FF, a set interrupt mask, and the vector pair 0xFFFE/0xFFFF.

The status register is read-only. It holds one hot bit that names the highest-priority cause of the latest reset. A debugger-forced reset writes all zeros. Power-on clears the pin-reset enable, and software sets it through a one-cycle write.

Top module: `rst_source_ctrl`

## Requirements
- R1: While any honoured request is high, `sys_rst` is high at the same time, with no clock edge needed.
- R2: `pin_req` causes no reset and leaves `rst_status` unchanged while `pin_en` is 0. `cfg_we` with `cfg_pin_en` loads `pin_en` at the next clock edge.
- R3: After the last request drops, `sys_rst` stays high through the 17th rising edge and falls after the 18th edge. This is 2 synchroniser edges plus HOLD=16.
- R4: `rst_status` is one-hot or zero, with this layout: bit0 power-on, bit1 pin, bit2 low-voltage, bit3 watchdog, bit4 illegal opcode, bit5 illegal address.
- R5: When several requests are active together, only one bit is recorded. The order from highest to lowest is power-on, low-voltage, pin, watchdog, illegal opcode, illegal address.
- R6: Power-on sets `rst_status` to 6'b000001 and clears `pin_en`.
- R7: A debugger-forced reset asserts `sys_rst` and sets `rst_status` to all zeros.
- R8: A bus access with `bus_valid` high to an address inside an unimplemented range (defaults 0x0100..0x017F and 0x1000..0x10FF) asserts `sys_rst` after the next rising edge. It records status bit5. An access outside these ranges causes nothing.
- R9: While `sys_rst` is high, `cpu_sp` is 0x00FF and `cpu_imask` is 1. Otherwise both are 0. `cpu_vec` is always 0xFFFE.
- R10: `rst_status` changes only at a clock edge where a request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_req | input | 1 | Power-on request, asynchronous, active high |
| pin_req | input | 1 | External pin reset request |
| lvd_req | input | 1 | Low-voltage request |
| wdog_req | input | 1 | Watchdog timeout request |
| iop_req | input | 1 | Illegal opcode request |
| dbg_req | input | 1 | Debugger-forced request |
| cfg_we | input | 1 | Write strobe for the pin-reset enable |
| cfg_pin_en | input | 1 | Value written to the pin-reset enable |
| bus_valid | input | 1 | Bus access strobe |
| bus_addr | input | AW | Bus access address |
| sys_rst | output | 1 | System reset, active high |
| rst_status | output | 6 | Cause of the latest reset, one-hot |
| pin_en | output | 1 | Current pin-reset enable |
| cpu_sp | output | 16 | Stack pointer initial value during reset |
| cpu_imask | output | 1 | Interrupt mask during reset |
| cpu_vec | output | 16 | Reset vector address, high byte |

## Verification
`sys_rst` rises combinationally with a request, so the bench checks it 1 ns after driving. An illegal address passes through one register, so that check waits one rising edge. Release is due exactly after the 18th edge following the drop of the request. The bench checks high after edge 17 and low after edge 18. `rst_status` is read only after release has completed. All stimulus changes on falling edges, and every sample is taken 1 ns after a rising edge.

// File: rtl/rst_source_ctrl.sv
module rst_source_ctrl #(
  parameter int AW = 16,
  parameter int HOLD = 16,
  parameter int NHOLE = 2,
  parameter logic [NHOLE*AW-1:0] HOLE_LO = {16'h1000, 16'h0100},
  parameter logic [NHOLE*AW-1:0] HOLE_HI = {16'h10FF, 16'h017F}
) (
  input  logic          clk,
  input  logic          por_req,
  input  logic          pin_req,
  input  logic          lvd_req,
  input  logic          wdog_req,
  input  logic          iop_req,
  input  logic          dbg_req,
  input  logic          cfg_we,
  input  logic          cfg_pin_en,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  output logic          sys_rst,
  output logic [5:0]    rst_status,
  output logic          pin_en,
  output logic [15:0]   cpu_sp,
  output logic          cpu_imask,
  output logic [15:0]   cpu_vec
);
  localparam int CW = $clog2(HOLD + 1);
  localparam int QW = $clog2(HOLD + 4) + 1;

  logic [NHOLE-1:0] hole_hit;
  logic             iad_q;
  logic [1:0]       sync;
  logic [CW-1:0]    cnt;
  logic [5:0]       cause;

  for (genvar g = 0; g < NHOLE; g++) begin : g_hole
    assign hole_hit[g] = (bus_addr >= HOLE_LO[g*AW +: AW]) && (bus_addr <= HOLE_HI[g*AW +: AW]);
  end

  wire pin_act = pin_req & pin_en;
  wire any_req = por_req | lvd_req | pin_act | wdog_req | iop_req | iad_q | dbg_req;

  always_ff @(posedge clk or posedge por_req)
    if (por_req) iad_q <= 1'b0;
    else         iad_q <= bus_valid && (|hole_hit);

  always_comb begin
    cause = '0;
    if      (por_req)  cause[0] = 1'b1;
    else if (lvd_req)  cause[2] = 1'b1;
    else if (pin_act)  cause[1] = 1'b1;
    else if (wdog_req) cause[3] = 1'b1;
    else if (iop_req)  cause[4] = 1'b1;
    else if (iad_q)    cause[5] = 1'b1;
  end

  always_ff @(posedge clk or posedge por_req)
    if (por_req) begin
      rst_status <= 6'b000001;
      pin_en     <= 1'b0;
    end else begin
      if (any_req) rst_status <= cause;
      if (cfg_we)  pin_en     <= cfg_pin_en;
    end

  always_ff @(posedge clk or posedge any_req)
    if (any_req) begin
      sync <= 2'b11;
      cnt  <= CW'(HOLD);
    end else begin
      sync <= {sync[0], 1'b0};
      if (sync[1])         cnt <= CW'(HOLD);
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

  assign sys_rst   = sync[1] | (cnt != '0);
  assign cpu_sp    = sys_rst ? 16'h00FF : 16'h0000;
  assign cpu_imask = sys_rst;
  assign cpu_vec   = 16'hFFFE;

  logic [QW-1:0] quiet;
  always_ff @(posedge clk or posedge any_req)
    if (any_req)              quiet <= '0;
    else if (quiet != '1)     quiet <= quiet + 1'b1;

  // R1
  req_rst_chk: assert property (@(posedge clk) disable iff (por_req) any_req |-> sys_rst);
  // R2
  pin_masked_chk: assert property (@(posedge clk) disable iff (por_req)
    (pin_req && !pin_en && !lvd_req && !wdog_req && !iop_req && !dbg_req && !iad_q && !sys_rst) |=> $stable(rst_status));
  // R3
  hold_min_chk: assert property (@(posedge clk) disable iff (por_req) $fell(sys_rst) |-> (quiet >= QW'(HOLD)));
  // R4
  status_onehot_chk: assert property (@(posedge clk) disable iff (por_req) $onehot0(rst_status));
  // R8
  bad_addr_chk: assert property (@(posedge clk) disable iff (por_req) (bus_valid && (|hole_hit)) |=> sys_rst);
  // R10
  status_hold_chk: assert property (@(posedge clk) disable iff (por_req) !any_req |=> $stable(rst_status));
endmodule

// File: tb/tb_rst_source_ctrl.sv
module tb_rst_source_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_req = 1'b1, pin_req = 1'b0, lvd_req = 1'b0, wdog_req = 1'b0, iop_req = 1'b0, dbg_req = 1'b0;
  logic cfg_we = 1'b0, cfg_pin_en = 1'b0, bus_valid = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic sys_rst, pin_en, cpu_imask;
  logic [5:0] rst_status;
  logic [15:0] cpu_sp, cpu_vec;

  rst_source_ctrl dut (
    .clk(clk), .por_req(por_req), .pin_req(pin_req), .lvd_req(lvd_req), .wdog_req(wdog_req),
    .iop_req(iop_req), .dbg_req(dbg_req), .cfg_we(cfg_we), .cfg_pin_en(cfg_pin_en),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .sys_rst(sys_rst), .rst_status(rst_status),
    .pin_en(pin_en), .cpu_sp(cpu_sp), .cpu_imask(cpu_imask), .cpu_vec(cpu_vec));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // entry: {dbg, iop, wdog, pin, lvd, expected status[5:0]}
  localparam int NV = 8;
  localparam logic [10:0] VEC [NV] = '{
    {5'b00001, 6'b000100},
    {5'b00010, 6'b000010},
    {5'b00100, 6'b001000},
    {5'b01000, 6'b010000},
    {5'b10000, 6'b000000},
    {5'b00110, 6'b000010},
    {5'b01011, 6'b000100},
    {5'b11100, 6'b001000}
  };

  task automatic release_wait();
    repeat (22) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R6 status after power-on", {10'd0, rst_status}, 16'h0001);
    check("R6 pin_en after power-on", {15'd0, pin_en}, 16'h0000);
    check("R9 sp in reset", cpu_sp, 16'h00FF);
    check("R9 imask in reset", {15'd0, cpu_imask}, 16'h0001);
    @(negedge clk); por_req = 1'b0;
    release_wait();
    check("R3 released after power-on", {15'd0, sys_rst}, 16'h0000);
    check("R9 sp out of reset", cpu_sp, 16'h0000);
    check("R9 imask out of reset", {15'd0, cpu_imask}, 16'h0000);
    check("R9 vector", cpu_vec, 16'hFFFE);

    // R2 pin request ignored while disabled
    pin_req = 1'b1; #1;
    check("R2 masked pin no reset", {15'd0, sys_rst}, 16'h0000);
    repeat (3) @(posedge clk); #1;
    check("R2 masked pin no reset later", {15'd0, sys_rst}, 16'h0000);
    check("R2 masked pin status kept", {10'd0, rst_status}, 16'h0001);
    @(negedge clk); pin_req = 1'b0;
    cfg_we = 1'b1; cfg_pin_en = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    check("R2 pin_en written", {15'd0, pin_en}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      {dbg_req, iop_req, wdog_req, pin_req, lvd_req} = VEC[i][10:6];
      #1;
      check("R1 reset follows request", {15'd0, sys_rst}, 16'h0001);
      repeat (2) @(posedge clk);
      @(negedge clk);
      {dbg_req, iop_req, wdog_req, pin_req, lvd_req} = 5'b0;
      release_wait();
      check("R5 R7 recorded cause", {10'd0, rst_status}, {10'd0, VEC[i][5:0]});
      check("R3 reset released", {15'd0, sys_rst}, 16'h0000);
    end

    // R3 exact release edge
    wdog_req = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); wdog_req = 1'b0;
    repeat (17) @(posedge clk); #1;
    check("R3 still high after edge 17", {15'd0, sys_rst}, 16'h0001);
    @(posedge clk); #1;
    check("R3 low after edge 18", {15'd0, sys_rst}, 16'h0000);
    @(negedge clk);

    // R8 legal address no effect
    bus_valid = 1'b1; bus_addr = 16'h0180;
    @(posedge clk); #1;
    check("R8 legal addr no reset", {15'd0, sys_rst}, 16'h0000);
    @(negedge clk); bus_addr = 16'h0FFF;
    @(posedge clk); #1;
    check("R8 legal addr below hole", {15'd0, sys_rst}, 16'h0000);
    @(negedge clk); bus_valid = 1'b0; bus_addr = 16'h0100;
    @(posedge clk); #1;
    check("R8 hole addr without strobe", {15'd0, sys_rst}, 16'h0000);
    check("R10 status kept", {10'd0, rst_status}, 16'h0008);
    // R8 illegal address
    @(negedge clk); bus_valid = 1'b1; bus_addr = 16'h10FF;
    @(posedge clk); #1;
    check("R8 illegal addr reset", {15'd0, sys_rst}, 16'h0001);
    @(negedge clk); bus_valid = 1'b0;
    release_wait();
    check("R8 illegal addr status", {10'd0, rst_status}, 16'h0020);
    check("R8 released", {15'd0, sys_rst}, 16'h0000);

    // R5 R6 power-on wins and clears pin enable
    lvd_req = 1'b1; wdog_req = 1'b1; por_req = 1'b1;
    #1;
    check("R6 power-on status", {10'd0, rst_status}, 16'h0001);
    check("R6 power-on clears pin_en", {15'd0, pin_en}, 16'h0000);
    @(negedge clk); por_req = 1'b0;
    @(negedge clk); lvd_req = 1'b0; wdog_req = 1'b0;
    release_wait();
    check("R5 lvd after power-on", {10'd0, rst_status}, 16'h0004);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule